// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block watches the clock and data lines of an I2C bus and reports what the bus is doing. It detects START and STOP conditions and keeps a bus-busy flag. That flag stays set for a programmable number of system clocks after a STOP, so a controller waiting for a free bus does not jump in too early. After every START or repeated START it collects the first seven address bits on the wire and compares them with a programmable own address. A match moves the block from master mode into slave mode.

A small status byte reports four things:
- a sticky arbitration-loss flag, set by a pulse from a separate master engine;
- a sticky flag for a STOP that arrived while the block was addressed as a slave;
- the busy flag;
- the mode bit.

Software clears the two sticky flags by writing ones to them. A second write target holds the own address. Byte shifting, acknowledge generation and clock generation are handled elsewhere.

The raw line inputs pass through a two-flop synchronizer inside the block. Every condition is detected on the synchronized values.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset the status byte reads 01h (master mode, every flag clear) and the own-address byte reads 00h.
- R2: `start_pulse` is high for exactly one clock when synchronized SDA falls while synchronized SCL is high. `stop_pulse` is high for exactly one clock when SDA rises while SCL is high. SDA changes while SCL is low produce neither pulse.
- R3: Status bit 1 (busy) becomes 1 in the clock after a START is detected.
- R4: After a STOP is detected, busy remains 1 for IDLE_CYC further clocks and then reads 0. A START detected within that window keeps busy at 1 without a gap.
- R5: The first 7 bits sampled on SCL rising edges after a START form the received address, most significant bit first. If they equal own-address bits 7..1, `addr_hit` pulses and status bit 0 (mode) becomes 0 (slave). Otherwise the mode is unchanged.
- R6: A detected STOP sets the mode bit back to 1 (master).
- R7: Status bit 2 becomes 1 when a STOP is detected while the mode bit is 0. It stays 1 until it is cleared.
- R8: Status bit 3 becomes 1 after a one-clock `arb_lost` pulse and stays 1 until it is cleared.
- R9: A write with `wr_sel`=0 clears status bit 3 and/or bit 2 where the written data bit is 1. Data bits written as 0 leave their flags unchanged, and writes to bits 1 and 0 have no effect.
- R10: When a set event and a write-one clear hit the same flag in the same clock, the flag ends up 1.
- R11: A write with `wr_sel`=1 loads data bits 7..1 into the own address. Bit 0 of the own-address byte always reads 0.
- R12: A repeated START (a START while busy) restarts address collection, so bits sent before it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| arb_lost | input | 1 | One-clock arbitration-loss pulse from the master engine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 own address |
| wr_data | input | 8 | Write data |
| status_q | output | 8 | Status byte: bit3 arbitration lost, bit2 slave STOP, bit1 busy, bit0 master mode |
| own_addr_q | output | 8 | Own address in bits 7..1; bit 0 reads 0 |
| start_pulse | output | 1 | START detected this clock |
| stop_pulse | output | 1 | STOP detected this clock |
| addr_hit | output | 1 | Received address matched this clock |

## Verification
- **Broken address collection** shows up as a wrong mode bit right after the eighth SCL pulse of a transfer. The mode bit is 0 where it should be 1, or 1 where it should be 0. It then surfaces a second time as a wrong slave-STOP flag a few clocks after the STOP.
- **A bad idle counter** moves the falling edge of busy by whole clocks. A sweep that samples busy on every clock after a STOP pins down the exact clock where it falls.
- **A bad restart path** opens a one-clock gap in busy.
- **A bad set/clear priority** drops a sticky flag in the same clock as the colliding write.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

  localparam int STAT_ARB   = 3;
  localparam int STAT_SSTOP = 2;
  localparam int STAT_BUSY  = 1;
  localparam int STAT_MODE  = 0;

  typedef enum logic {
    SEL_STATUS  = 1'b0,
    SEL_OWNADDR = 1'b1
  } wsel_e;

  // SDA falling while SCL held high over two samples
  function automatic logic cond_start(input logic scl_now, input logic scl_prev,
                                      input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & sda_prev & ~sda_now;
  endfunction

  // SDA rising while SCL held high over two samples
  function automatic logic cond_stop(input logic scl_now, input logic scl_prev,
                                     input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & ~sda_prev & sda_now;
  endfunction

  // sticky flag next value: a set event beats a clear
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr);
    return set_ev | (cur & ~clr);
  endfunction

  function automatic logic addr_same(input logic [6:0] a, input logic [6:0] b);
    return (a == b);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic start_ev,
  output logic stop_ev
);
  import i2c_watch_pkg::*;

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_s;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_raw;
          sda_chain <= sda_raw;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
          sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign start_ev = cond_start(scl_s, scl_d, sda_s, sda_d);
  assign stop_ev  = cond_stop(scl_s, scl_d, sda_s, sda_d);

endmodule

// File: rtl/i2c_addr_capture.sv
module i2c_addr_capture #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit
);
  import i2c_watch_pkg::*;

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

  logic              armed;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-2:0] shreg;
  logic              last_bit;
  logic [ADDR_W-1:0] rx_addr;

  assign last_bit = armed & scl_rise & (bit_cnt == LAST);
  assign rx_addr  = {shreg, sda_s};
  assign hit      = last_bit & addr_same(7'(rx_addr), 7'(own_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (start_ev) begin
      armed   <= 1'b1;
      bit_cnt <= '0;
    end else if (stop_ev) begin
      armed   <= 1'b0;
    end else if (armed && scl_rise) begin
      if (bit_cnt == LAST) begin
        armed <= 1'b0;
      end else begin
        shreg   <= {shreg[ADDR_W-3:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int IDLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ev,
  input  logic stop_ev,
  output logic busy
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(IDLE_CYC);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idle_cnt <= '0;
    end else if (start_ev) begin
      busy     <= 1'b1;
      idle_cnt <= '0;
    end else if (stop_ev) begin
      idle_cnt <= LOAD;
    end else if (idle_cnt != '0) begin
      idle_cnt <= idle_cnt - 1'b1;
      if (idle_cnt == CW'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int IDLE_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_raw,
  input  logic       sda_raw,
  input  logic       arb_lost,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] status_q,
  output logic [7:0] own_addr_q,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       addr_hit
);
  import i2c_watch_pkg::*;

  logic       sda_s;
  logic       scl_rise;
  logic       busy;
  logic       mode_master;
  logic       flag_arb;
  logic       flag_sstop;
  logic [6:0] own_addr;
  logic       wr_status;
  logic       wr_own;
  logic       slave_stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_raw (scl_raw),
    .sda_raw (sda_raw),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .start_ev(start_pulse),
    .stop_ev (stop_pulse)
  );

  i2c_addr_capture #(.ADDR_W(7)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ev(start_pulse),
    .stop_ev (stop_pulse),
    .scl_rise(scl_rise),
    .sda_s   (sda_s),
    .own_addr(own_addr),
    .hit     (addr_hit)
  );

  i2c_busy_timer #(.IDLE_CYC(IDLE_CYC)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ev(start_pulse),
    .stop_ev (stop_pulse),
    .busy    (busy)
  );

  assign wr_status     = wr_en & (wsel_e'(wr_sel) == SEL_STATUS);
  assign wr_own        = wr_en & (wsel_e'(wr_sel) == SEL_OWNADDR);
  assign slave_stop_ev = stop_pulse & ~mode_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_master <= 1'b1;
      flag_arb    <= 1'b0;
      flag_sstop  <= 1'b0;
      own_addr    <= '0;
    end else begin
      if (stop_pulse)    mode_master <= 1'b1;
      else if (addr_hit) mode_master <= 1'b0;
      flag_arb   <= sticky_next(flag_arb, arb_lost,
                                wr_status & wr_data[STAT_ARB]);
      flag_sstop <= sticky_next(flag_sstop, slave_stop_ev,
                                wr_status & wr_data[STAT_SSTOP]);
      if (wr_own) own_addr <= wr_data[7:1];
    end
  end

  assign status_q   = {4'b0000, flag_arb, flag_sstop, busy, mode_master};
  assign own_addr_q = {own_addr, 1'b0};

endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk #(
  parameter int IDLE_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       arb_lost,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       addr_hit,
  input logic [7:0] status_q,
  input logic [7:0] own_addr_q
);
  localparam int QW = $clog2(IDLE_CYC + 2) + 1;

  logic [QW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= '0;
    else if (stop_pulse) quiet <= QW'(1);
    else if (start_pulse) quiet <= '0;
    else if (quiet != '0 && quiet <= QW'(IDLE_CYC)) quiet <= quiet + 1'b1;
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse)); // R2
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> status_q[1]); // R3
  AST_BUSY_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet == QW'(IDLE_CYC + 1)) |-> !status_q[1]); // R4
  AST_HIT_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> !status_q[0]); // R5
  AST_STOP_TO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> status_q[0]); // R6
  AST_SLAVE_STOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !status_q[0]) |=> status_q[2]); // R7
  AST_ARB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> status_q[3]); // R8
  AST_OWN_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !own_addr_q[0]); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7:4] == 4'b0000); // R9

endmodule

bind i2c_bus_watch i2c_bus_watch_chk #(.IDLE_CYC(IDLE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arb_lost   (arb_lost),
  .start_pulse(start_pulse),
  .stop_pulse (stop_pulse),
  .addr_hit   (addr_hit),
  .status_q   (status_q),
  .own_addr_q (own_addr_q)
);

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;
  localparam int IDLE = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       arb_lost = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status_q;
  logic [7:0] own_addr_q;
  logic       start_pulse;
  logic       stop_pulse;
  logic       addr_hit;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_stop = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bus_watch #(.IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl), .sda_raw(sda),
    .arb_lost(arb_lost), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_q(status_q), .own_addr_q(own_addr_q),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .addr_hit(addr_hit)
  );

  always @(negedge clk) begin
    if (start_pulse) n_start++;
    if (stop_pulse)  n_stop++;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    wt(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic bus_start;
    sda = 1'b1; wt(2); scl = 1'b1; wt(4); sda = 1'b0; wt(4); scl = 1'b0; wt(3);
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wt(3); scl = 1'b1; wt(4); scl = 1'b0; wt(3);
  endtask

  task automatic bus_stop;
    scl = 1'b0; sda = 1'b0; wt(3); scl = 1'b1; wt(4); sda = 1'b1; wt(4);
  endtask

  task automatic send_addr(input logic [6:0] a);
    for (int i = 6; i >= 0; i--) bus_bit(a[i]);
    bus_bit(1'b0);
  endtask

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(2);
    chk("R1 status", status_q, 8'h01);
    chk("R1 own", own_addr_q, 8'h00);

    // R2: SDA toggles with SCL low make no conditions
    scl = 1'b0; wt(3);
    for (int i = 0; i < 6; i++) begin sda = ~sda; wt(4); end
    chk("R2 no start", n_start, 0);
    chk("R2 no stop", n_stop, 0);
    bus_start;
    chk("R2 one start", n_start, 1);
    chk("R3 busy", status_q[1], 1);
    send_addr(7'h15);
    bus_stop;
    chk("R2 start count", n_start, 1);
    chk("R2 one stop", n_stop, 1);
    wt(IDLE + 4);
    chk("R4 idle after", status_q[1], 0);

    // R11 own address register
    wr(1'b1, 8'hFF);
    chk("R11 own ff", own_addr_q, 8'hFE);
    wr(1'b1, 8'h00);

    // R5/R6/R7 sweep over own addresses and all received addresses
    for (int k = 0; k < 3; k++) begin
      logic [6:0] own;
      own = (k == 0) ? 7'h00 : (k == 1) ? 7'h2A : 7'h7F;
      wr(1'b1, {own, 1'b1});
      chk("R11 own load", own_addr_q, {own, 1'b0});
      for (int a = 0; a < 128; a++) begin
        bit m;
        m = (7'(a) == own);
        bus_start;
        send_addr(7'(a));
        chk("R5 mode after addr", status_q[0], m ? 0 : 1);
        bus_stop;
        wt(2);
        chk("R6 master after stop", status_q[0], 1);
        chk("R7 slave stop flag", status_q[2], m ? 1 : 0);
        if (m) begin
          wr(1'b0, 8'h04);
          chk("R9 clear slave stop", status_q[2], 0);
        end
        wt(IDLE);
      end
    end

    // R12 repeated start discards earlier bits
    wr(1'b1, 8'h54);
    bus_start;
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    bus_start;
    send_addr(7'h2A);
    chk("R12 repeated start match", status_q[0], 0);
    bus_start;
    bus_bit(1'b0); bus_bit(1'b1);
    bus_start;
    bus_stop;
    wt(IDLE + 4);
    wr(1'b0, 8'h0C);
    bus_start;
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start;
    send_addr(7'h55);
    chk("R12 no match after restart", status_q[0], 1);
    bus_stop;
    wt(IDLE + 4);

    // R4 busy fall timing sweep
    bus_start;
    scl = 1'b1; wt(4);
    sda = 1'b1;
    for (int k = 1; k <= IDLE + 4; k++) begin
      wt(1);
      chk("R4 busy window", status_q[1], (k < IDLE + 3) ? 1 : 0);
    end

    // R4 start within window keeps busy
    for (int d = 1; d < IDLE; d++) begin
      bus_start;
      scl = 1'b1; wt(4);
      sda = 1'b1;
      wt(d);
      sda = 1'b0;
      for (int k = 0; k < IDLE + 6; k++) begin
        wt(1);
        chk("R4 busy kept", status_q[1], 1);
      end
      bus_stop;
      wt(IDLE + 4);
    end

    // R8/R9/R10 sticky flags
    arb_lost = 1'b1; wt(1); arb_lost = 1'b0;
    chk("R8 arb set", status_q[3], 1);
    wt(3);
    chk("R8 arb sticky", status_q[3], 1);
    wr(1'b0, 8'h04);
    chk("R9 zero bit keeps arb", status_q[3], 1);
    wr(1'b0, 8'h03);
    chk("R9 ro bits", status_q, 8'h09);
    wr(1'b1, 8'h08);
    chk("R9 own write no clear", status_q[3], 1);
    wr(1'b0, 8'h08);
    chk("R9 arb clear", status_q[3], 0);
    arb_lost = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h08;
    wt(1);
    arb_lost = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    chk("R10 set wins", status_q[3], 1);
    wr(1'b0, 8'h08);
    chk("R10 then clear", status_q, 8'h01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule